// File: doc/BRIEF.md
# Multicycle Datapath for a Five-Instruction RISC Subset

This block holds the state of a 32-bit processor that runs each instruction over several clock cycles: a program counter, an instruction register, two operand registers, an ALU result register, a memory data register and a register file. One adder serves all arithmetic. In one cycle it computes PC+4, in another a load or store address, and in another a branch target. One memory port serves both instruction fetch and data access. A multiplexer picks whether the port sees the program counter or the result register. Jump targets are formed by concatenation and do not use the adder.

The block makes no decisions of its own. Every register enable and every multiplexer select is an input, driven by an external sequencer. The sequencer decodes the opcode from the instruction register output and uses the equality flag to resolve branches. The memory sits outside the block. It returns the word at the presented address combinationally and takes a write on the clock edge when the write strobe is high.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter and instruction register are cleared to zero. All register-file entries and internal operand registers are also cleared.
- R2: Fetch uses `addr_sel`=0, `ir_we`=1, `pc_we`=1, `pc_src`=0, `alu_a_sel`=0 and `alu_b_sel`=1. On one edge, this loads the instruction register with the memory word at the old PC, and the PC becomes old PC + 4.
- R3: With `ab_we`=1, the A register loads register-file entry rs (instruction bits 25:21) and B loads entry rt (bits 20:16).
- R4: With `alu_a_sel`=1, `alu_b_sel`=2 and `res_we`=1, the result register loads A plus the sign-extended instruction bits 15:0. The bench observes this on `mem_addr` when `addr_sel`=1.
- R5: With `addr_sel`=1 and `mdr_we`=1, the data register loads the memory word at the result address. A later cycle with `rf_we`=1, `wb_dst_sel`=0 and `wb_src_sel`=1 writes that word to entry rt.
- R6: With `addr_sel`=1, `mem_addr` equals the result register, `mem_wdata` equals B, and `mem_wr` follows `mem_we`.
- R7: With `alu_a_sel`=1, `alu_b_sel`=0 and `res_we`=1, the result register loads A+B modulo 2^32. A later cycle with `rf_we`=1, `wb_dst_sel`=1 and `wb_src_sel`=0 writes it to entry rd (bits 15:11).
- R8: With `alu_a_sel`=0, `alu_b_sel`=3 and `res_we`=1, the result register loads PC plus the sign-extended immediate shifted left by two. A later cycle with `pc_we_cond`=1 and `pc_src`=1 loads PC from the result register only when A equals B (`eq_o`=1); otherwise PC is unchanged.
- R9: With `pc_we`=1 and `pc_src`=2, PC becomes {PC[31:28], IR[25:0], 2'b00}.
- R10: Register-file entry 0 always reads as zero, and writes to it have no effect.
- R11: A register whose enable is low keeps its value: PC with both `pc_we` and `pc_we_cond` low, IR with `ir_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write qualified by A==B |
| pc_src | input | 2 | PC source: 0 adder, 1 result register, 2 jump concat |
| ir_we | input | 1 | Instruction register write |
| ab_we | input | 1 | A/B operand register write |
| res_we | input | 1 | Result register write |
| mdr_we | input | 1 | Memory data register write |
| rf_we | input | 1 | Register file write |
| alu_a_sel | input | 1 | Adder A input: 0 PC, 1 A |
| alu_b_sel | input | 2 | Adder B input: 0 B, 1 constant 4, 2 sext imm, 3 sext imm<<2 |
| addr_sel | input | 1 | Memory address: 0 PC, 1 result register |
| wb_dst_sel | input | 1 | Write-back index: 0 rt, 1 rd |
| wb_src_sel | input | 1 | Write-back data: 0 result register, 1 data register |
| mem_we | input | 1 | Memory write request |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Byte address to memory |
| mem_wdata | output | 32 | Store data (B register) |
| mem_wr | output | 1 | Memory write strobe |
| ir_o | output | 32 | Instruction register |
| pc_o | output | 32 | Program counter |
| eq_o | output | 1 | A equals B |

## Verification
Fetch puts two updates on one edge. The instruction register captures the memory word addressed by the PC, while the PC is overwritten with the adder output. A fault in either path would either latch the word at the new PC or let the PC skip. Every instruction in the bench begins with such a fetch, and the fetched word is written fresh into the bench memory beforehand. After the edge, the bench compares the instruction register with that word and the PC with the old value plus four. The branch decode cycle also overlaps two updates: operand loading and target computation share one edge. A sweep of all operand-register pairs then shows that the taken/not-taken outcome follows the operand values that were just loaded.

// File: rtl/mc_pkg.sv
// Package: select encodings shared by the datapath and its sub-blocks.
// Assumes: the encodings below match the external sequencer.
package mc_pkg;
    localparam logic [1:0] PCSRC_ALU  = 2'd0;
    localparam logic [1:0] PCSRC_RES  = 2'd1;
    localparam logic [1:0] PCSRC_JUMP = 2'd2;

    localparam logic [1:0] ALUB_REG    = 2'd0;
    localparam logic [1:0] ALUB_FOUR   = 2'd1;
    localparam logic [1:0] ALUB_IMM    = 2'd2;
    localparam logic [1:0] ALUB_IMM_SH = 2'd3;

    localparam int IMM_W    = 16;
    localparam int TARGET_W = 26;
endpackage

// File: rtl/mc_regfile.sv
// Module: register file with two combinational read ports and one write port.
// Assumes: entry 0 is hardwired to zero by never being written.
module mc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RIDX = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] rd_a_idx,
    input  logic [RIDX-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [RIDX-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data
);
    logic [XLEN-1:0] regs [NREGS];

    // Storage update: clear on reset, write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wr_idx != '0)) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];
endmodule

// File: rtl/mc_alu_path.sv
// Module: operand multiplexers and the single shared adder.
// Assumes: immediate arrives already sign-extended to XLEN.
module mc_alu_path #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    input  logic [XLEN-1:0] imm_sext,
    input  logic            a_sel,
    input  logic [1:0]      b_sel,
    output logic [XLEN-1:0] sum
);
    import mc_pkg::*;
    logic [XLEN-1:0] op_a, op_b;

    // Operand selection for the adder.
    always_comb begin
        op_a = a_sel ? a_val : pc;
        unique case (b_sel)
            ALUB_REG:  op_b = b_val;
            ALUB_FOUR: op_b = XLEN'(4);
            ALUB_IMM:  op_b = imm_sext;
            default:   op_b = {imm_sext[XLEN-3:0], 2'b00};
        endcase
    end

    assign sum = op_a + op_b;
endmodule

// File: rtl/mc_pc_unit.sv
// Module: program counter with next-value mux and qualified write enable.
// Assumes: XLEN >= 32 so the jump concatenation fills the word.
module mc_pc_unit #(
    parameter int XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pc_we,
    input  logic                         pc_we_cond,
    input  logic                         operands_eq,
    input  logic [1:0]                   pc_src,
    input  logic [XLEN-1:0]              alu_sum,
    input  logic [XLEN-1:0]              res_val,
    input  logic [mc_pkg::TARGET_W-1:0]  target,
    output logic [XLEN-1:0]              pc_q
);
    import mc_pkg::*;
    localparam int HI_W = XLEN - TARGET_W - 2;
    logic [XLEN-1:0] pc_next;
    logic            pc_load;

    // Next-PC source selection.
    always_comb begin
        unique case (pc_src)
            PCSRC_ALU:  pc_next = alu_sum;
            PCSRC_RES:  pc_next = res_val;
            default:    pc_next = {pc_q[XLEN-1 -: HI_W], target, 2'b00};
        endcase
    end

    assign pc_load = pc_we || (pc_we_cond && operands_eq);

    // PC register with reset value and write qualification.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= RESET_PC;
        else if (pc_load) pc_q <= pc_next;
    end

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && !pc_we_cond) |=> $stable(pc_q));
    assert_branch_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we && pc_we_cond && !operands_eq) |=> $stable(pc_q));
    assert_jump_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src == PCSRC_JUMP) |=>
        (pc_q[XLEN-1 -: HI_W] == $past(pc_q[XLEN-1 -: HI_W]) && pc_q[1:0] == 2'b00));
endmodule

// File: rtl/mc_datapath.sv
// Module: multicycle datapath top: IR, A/B, result and data registers,
// register file, shared adder, PC unit and the memory address mux.
// Assumes: memory read is combinational, writes occur on the clock edge.
module mc_datapath #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            pc_we_cond,
    input  logic [1:0]      pc_src,
    input  logic            ir_we,
    input  logic            ab_we,
    input  logic            res_we,
    input  logic            mdr_we,
    input  logic            rf_we,
    input  logic            alu_a_sel,
    input  logic [1:0]      alu_b_sel,
    input  logic            addr_sel,
    input  logic            wb_dst_sel,
    input  logic            wb_src_sel,
    input  logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_wr,
    output logic [XLEN-1:0] ir_o,
    output logic [XLEN-1:0] pc_o,
    output logic            eq_o
);
    import mc_pkg::*;
    localparam int RIDX = $clog2(NREGS);

    logic [XLEN-1:0] ir_q, a_q, b_q, res_q, mdr_q;
    logic [XLEN-1:0] rf_a, rf_b, alu_sum, imm_sext, pc_q;
    logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic [XLEN-1:0] wb_data;

    assign rs_idx   = ir_q[21 +: RIDX];
    assign rt_idx   = ir_q[16 +: RIDX];
    assign rd_idx   = ir_q[11 +: RIDX];
    assign imm_sext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign wb_idx   = wb_dst_sel ? rd_idx : rt_idx;
    assign wb_data  = wb_src_sel ? mdr_q : res_q;

    // Architectural registers, each behind its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ir_we)  ir_q  <= mem_rdata;
            if (ab_we)  a_q   <= rf_a;
            if (ab_we)  b_q   <= rf_b;
            if (res_we) res_q <= alu_sum;
            if (mdr_we) mdr_q <= mem_rdata;
        end
    end

    mc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) rf_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rs_idx), .rd_b_idx(rt_idx),
        .rd_a(rf_a), .rd_b(rf_b),
        .we(rf_we), .wr_idx(wb_idx), .wr_data(wb_data)
    );

    mc_alu_path #(.XLEN(XLEN)) alu_i (
        .pc(pc_q), .a_val(a_q), .b_val(b_q), .imm_sext(imm_sext),
        .a_sel(alu_a_sel), .b_sel(alu_b_sel), .sum(alu_sum)
    );

    mc_pc_unit #(.XLEN(XLEN), .RESET_PC(RESET_PC)) pc_i (
        .clk(clk), .rst_n(rst_n),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .operands_eq(eq_o),
        .pc_src(pc_src), .alu_sum(alu_sum), .res_val(res_q),
        .target(ir_q[TARGET_W-1:0]), .pc_q(pc_q)
    );

    assign mem_addr  = addr_sel ? res_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_wr    = mem_we;
    assign ir_o      = ir_q;
    assign pc_o      = pc_q;
    assign eq_o      = (a_q == b_q);

    assert_fetch_ir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_we && !addr_sel) |=> (ir_q == $past(mem_rdata)));
    assert_fetch_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src == PCSRC_ALU && !alu_a_sel && alu_b_sel == ALUB_FOUR)
        |=> (pc_q == $past(pc_q) + XLEN'(4)));
    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_we && rs_idx == '0) |=> (a_q == '0));
    assert_ir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> $stable(ir_q));
endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic pc_we, pc_we_cond, ir_we, ab_we, res_we, mdr_we, rf_we;
    logic alu_a_sel, addr_sel, wb_dst_sel, wb_src_sel, mem_we;
    logic [1:0] pc_src, alu_b_sel;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, ir_o, pc_o;
    logic mem_wr, eq_o;

    logic [31:0] mem [256];
    logic [31:0] mreg [32];
    logic [31:0] mpc;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .pc_src(pc_src), .ir_we(ir_we), .ab_we(ab_we), .res_we(res_we),
        .mdr_we(mdr_we), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .addr_sel(addr_sel), .wb_dst_sel(wb_dst_sel),
        .wb_src_sel(wb_src_sel), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .ir_o(ir_o), .pc_o(pc_o), .eq_o(eq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; pc_we_cond = 0; pc_src = 0; ir_we = 0; ab_we = 0;
        res_we = 0; mdr_we = 0; rf_we = 0; alu_a_sel = 0; alu_b_sel = 0;
        addr_sel = 0; wb_dst_sel = 0; wb_src_sel = 0; mem_we = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] sx(input logic [15:0] imm);
        return {{16{imm[15]}}, imm};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    // R2: fetch with the word placed fresh at the PC
    task automatic fetch(input logic [31:0] instr);
        mem[mpc[9:2]] = instr;
        idle(); ir_we = 1; pc_we = 1; pc_src = 0; alu_a_sel = 0; alu_b_sel = 1;
        tick();
        chk("R2 ir after fetch", ir_o, instr);
        chk("R2 pc after fetch", pc_o, mpc + 32'd4);
        mpc = mpc + 32'd4;
    endtask

    // R3 / R8: decode loads A, B and the branch target together
    task automatic decode();
        idle(); ab_we = 1; alu_a_sel = 0; alu_b_sel = 3; res_we = 1;
        tick();
    endtask

    task automatic addr_calc();
        idle(); alu_a_sel = 1; alu_b_sel = 2; res_we = 1;
        tick();
    endtask

    task automatic do_lw(input int rt, input int rs, input logic [15:0] imm);
        logic [31:0] ea;
        fetch(enc_i(6'h23, rs, rt, imm));
        decode();
        addr_calc();
        ea = mreg[rs] + sx(imm);
        idle(); addr_sel = 1; mdr_we = 1; #1;
        chk("R4 load address", mem_addr, ea);
        @(negedge clk);
        idle(); rf_we = 1; wb_dst_sel = 0; wb_src_sel = 1;
        tick();
        if (rt != 0) mreg[rt] = mem[ea[9:2]];
    endtask

    task automatic do_sw(input int rt, input int rs, input logic [15:0] imm, input string tag);
        logic [31:0] ea;
        fetch(enc_i(6'h2b, rs, rt, imm));
        decode();
        addr_calc();
        ea = mreg[rs] + sx(imm);
        idle(); addr_sel = 1; mem_we = 1; #1;
        chk({tag, " store address R6"}, mem_addr, ea);
        chk({tag, " store data"}, mem_wdata, mreg[rt]);
        chk("R6 write strobe", {31'd0, mem_wr}, 32'd1);
        @(posedge clk);
        mem[ea[9:2]] = mem_wdata;
        @(negedge clk);
    endtask

    task automatic do_add(input int rd, input int rs, input int rt);
        fetch({6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20});
        decode();
        idle(); alu_a_sel = 1; alu_b_sel = 0; res_we = 1;
        tick();
        idle(); rf_we = 1; wb_dst_sel = 1; wb_src_sel = 0;
        tick();
        if (rd != 0) mreg[rd] = mreg[rs] + mreg[rt];
    endtask

    task automatic do_beq(input int rs, input int rt, input logic [15:0] imm);
        logic [31:0] tgt;
        fetch(enc_i(6'h04, rs, rt, imm));
        decode();
        tgt = mpc + {sx(imm)[29:0], 2'b00};
        idle(); pc_src = 1; pc_we_cond = 1;
        tick();
        if (mreg[rs] == mreg[rt]) mpc = tgt;
        chk("R8 pc after branch", pc_o, mpc);
    endtask

    task automatic do_j(input logic [25:0] t);
        fetch({6'h02, t});
        idle(); pc_we = 1; pc_src = 2;
        tick();
        mpc = {mpc[31:28], t, 2'b00};
        chk("R9 pc after jump", pc_o, mpc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [31:0] hold_pc, hold_ir;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7fff_ffff;
        vals[3] = 32'hffff_ffff; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
        vals[6] = 32'hdead_beef; vals[7] = 32'h0000_0001;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
        for (int k = 0; k < 8; k++) mem[200 + k] = vals[k];
        mem[208] = 32'd804;
        mpc = 32'h0;
        idle();
        rst_n = 0;
        @(negedge clk); tick();
        chk("R1 pc at reset", pc_o, 32'h0);
        chk("R1 ir at reset", ir_o, 32'h0);
        rst_n = 1;

        // R5: load data words into r1..r8, r11
        for (int k = 0; k < 8; k++) do_lw(k + 1, 0, 16'(800 + 4 * k));
        do_lw(11, 0, 16'd832);
        // R4: negative offset from a base register
        do_lw(10, 11, 16'hfffc);
        do_sw(10, 0, 16'd884, "R5 loaded value");
        do_sw(3, 11, 16'hfffc, "R4 negative offset");
        mem[200] = vals[0];

        // R7: exhaustive add sweep over the loaded operands, observed via stores
        for (int i = 1; i <= 8; i++) begin
            for (int j = 1; j <= 8; j++) begin
                do_add(9, i, j);
                do_sw(9, 0, 16'd880, "R7 sum");
            end
        end

        // R10: writes to entry 0 are ignored, reads give zero
        do_lw(0, 0, 16'd812);
        do_add(0, 5, 6);
        do_sw(0, 0, 16'd888, "R10 zero register");
        do_add(12, 0, 5);
        do_sw(12, 0, 16'd888, "R10 zero operand");

        // R9: jump back to low memory
        do_j(26'd4);

        // R8: branch sweep over all operand pairs, forward offset
        for (int i = 1; i <= 8; i++) begin
            for (int j = 1; j <= 8; j++) do_beq(i, j, 16'd1);
        end
        // R8: backward offsets
        do_beq(2, 2, 16'hfffe);
        do_beq(2, 3, 16'hfff0);
        do_j(26'h3ff_fff0 >> 4);

        // R11: with every enable low, PC and IR keep their values
        hold_pc = pc_o; hold_ir = ir_o;
        mem[pc_o[9:2]] = 32'hcafe_f00d;
        idle(); tick(); tick();
        chk("R11 pc hold", pc_o, hold_pc);
        chk("R11 ir hold", ir_o, hold_ir);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule